// File: doc/BRIEF.md
# Parallel IO port with edge-capture interrupts

A memory-mapped parallel port of `WIDTH` bits (1 to 32). It has four word registers on a simple single-cycle register bus: the port data, the per-bit direction, the interrupt enable mask and the sticky edge-capture flags. The port drives an output latch onto `pin_out` and supplies a per-bit output enable `pin_oe` for external tri-state pads. It samples `pin_in` through a two-flop synchroniser. It detects edges on the synchronised value and records each detected edge in a capture flag that stays set.

The parameter `PORT_KIND` selects the build: 0 gives an input-only port, 1 an output-only port and 2 a bidirectional port. The parameter `EDGE_KIND` selects the edge that is captured: 0 for rising, 1 for falling and 2 for either edge. The `irq` output is a level. It is high while any capture flag is set whose mask bit is also set. Software clears a flag by writing a 1 to its bit position.

Top module: `pario_port`

## Requirements
- R1: After reset the output latch, direction, mask and capture registers are all zero and `irq` is low. `pin_oe` is zero for input-only and bidirectional builds and all ones for the output-only build.
- R2: A bus write (`bus_sel` and `bus_we` high) to word address 0 loads `bus_wdata` into the output latch. `pin_out` shows the new value after that clock edge. The input-only build keeps `pin_out` at zero.
- R3: In the bidirectional build, a write to address 1 sets `pin_oe` bit by bit (1 means drive) and reads back at address 1. Writes to address 1 have no effect in the other builds, where `pin_oe` stays fixed as stated in R1.
- R4: With `EDGE_KIND`=0, a capture bit sets only when its synchronised pin goes from 0 to 1.
- R5: With `EDGE_KIND`=1, a capture bit sets only when its synchronised pin goes from 1 to 0.
- R6: With `EDGE_KIND`=2, a capture bit sets on any change of its synchronised pin. In every mode, a pin change applied before a clock edge appears in the capture register (address 3) after the third rising edge and not after the second. The output-only build never sets a capture bit.
- R7: Capture bits are sticky. A write to address 3 clears exactly the bits written as 1 and leaves the bits written as 0 unchanged.
- R8: `irq` is high exactly when (capture AND mask) is nonzero. The mask is written and read at address 2.
- R9: A read at address 0 returns the synchronised pin value two clock edges after a pin change in builds that have inputs. The output-only build returns the output latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write enable, qualified by `bus_sel` |
| bus_addr | input | 2 | Word address: 0 data, 1 direction, 2 mask, 3 capture |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Combinational read data for `bus_addr` |
| pin_in | input | WIDTH | Asynchronous pin inputs |
| pin_out | output | WIDTH | Output latch to the pads |
| pin_oe | output | WIDTH | Per-bit output enable for the pads |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that the bus controls are known from time zero and that reset is held for at least one clock. They also assume that `pin_in` is low while reset is asserted, so that no edge is seen spuriously when reset is released. The stimulus keeps the pins at zero through reset and changes pins and bus signals only at falling clock edges. Before it clears the capture flags, it waits until the synchroniser has settled on the previous pin value, so that each pin transition is captured or cleared in a known cycle.

// File: rtl/pario_port.sv
module pario_port #(
  parameter int WIDTH     = 8,
  parameter int PORT_KIND = 2,
  parameter int EDGE_KIND = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe,
  output logic             irq
);
  localparam bit HAS_IN  = (PORT_KIND != 1);
  localparam bit HAS_OUT = (PORT_KIND != 0);
  localparam bit HAS_DIR = (PORT_KIND == 2);

  logic [WIDTH-1:0] out_q, dir_q, mask_q, cap_q;
  logic [WIDTH-1:0] sync1, sync2, sync3, edge_hit, clr_bits;
  logic wr;

  assign wr = bus_sel & bus_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      sync3 <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
      sync3 <= sync2;
    end
  end

  generate
    if (!HAS_IN) begin : g_no_edge
      assign edge_hit = '0;
    end else if (EDGE_KIND == 0) begin : g_rise
      assign edge_hit = sync2 & ~sync3;
    end else if (EDGE_KIND == 1) begin : g_fall
      assign edge_hit = ~sync2 & sync3;
    end else begin : g_any
      assign edge_hit = sync2 ^ sync3;
    end
  endgenerate

  assign clr_bits = (wr && bus_addr == 2'd3) ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      mask_q <= '0;
      cap_q  <= '0;
    end else begin
      if (wr && bus_addr == 2'd0) out_q <= bus_wdata;
      if (HAS_DIR && wr && bus_addr == 2'd1) dir_q <= bus_wdata;
      if (wr && bus_addr == 2'd2) mask_q <= bus_wdata;
      cap_q <= (cap_q & ~clr_bits) | edge_hit;
    end
  end

  assign pin_out = HAS_OUT ? out_q : '0;
  assign pin_oe  = HAS_DIR ? dir_q : (HAS_OUT ? '1 : '0);
  assign irq     = |(cap_q & mask_q);

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = HAS_IN ? sync2 : out_q;
      2'd1:    bus_rdata = pin_oe;
      2'd2:    bus_rdata = mask_q;
      default: bus_rdata = cap_q;
    endcase
  end
endmodule

// File: rtl/pario_port_chk.sv
module pario_port_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_we,
  input logic [1:0]       bus_addr,
  input logic [WIDTH-1:0] pin_out,
  input logic             irq,
  input logic [WIDTH-1:0] cap_q,
  input logic [WIDTH-1:0] mask_q,
  input logic [WIDTH-1:0] sync_cur,
  input logic [WIDTH-1:0] sync_prev
);
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!irq && cap_q == '0));

  p_out_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_sel && bus_we && bus_addr == 2'd0) |-> $stable(pin_out));

  p_cap_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((cap_q & ~$past(cap_q)) != '0) |-> ($past(sync_cur) != $past(sync_prev)));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_sel && bus_we && bus_addr == 2'd3) |-> ((cap_q & $past(cap_q)) == $past(cap_q)));

  p_mask_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);

  p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cap_q != '0));
endmodule

bind pario_port pario_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
  .pin_out(pin_out), .irq(irq), .cap_q(cap_q), .mask_q(mask_q),
  .sync_cur(sync2), .sync_prev(sync3)
);

// File: tb/test_pario_port.sv
`timescale 1ns/1ps
module test_pario_port;
  localparam int W = 4;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_we = 0;
  logic [1:0] bus_addr = 0;
  logic [W-1:0] bus_wdata = 0, pins = 0;
  logic [W-1:0] rd_a, rd_r, rd_f, rd_o, po_a, po_r, po_f, po_o, oe_a, oe_r, oe_f, oe_o;
  logic irq_a, irq_r, irq_f, irq_o;
  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  pario_port #(.WIDTH(W), .PORT_KIND(2), .EDGE_KIND(2)) i_pario_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_a), .pin_in(pins), .pin_out(po_a), .pin_oe(oe_a), .irq(irq_a));
  pario_port #(.WIDTH(W), .PORT_KIND(0), .EDGE_KIND(0)) i_pario_port_r (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_r), .pin_in(pins), .pin_out(po_r), .pin_oe(oe_r), .irq(irq_r));
  pario_port #(.WIDTH(W), .PORT_KIND(2), .EDGE_KIND(1)) i_pario_port_f (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_f), .pin_in(pins), .pin_out(po_f), .pin_oe(oe_f), .irq(irq_f));
  pario_port #(.WIDTH(W), .PORT_KIND(1), .EDGE_KIND(2)) i_pario_port_o (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_o), .pin_in(pins), .pin_out(po_o), .pin_oe(oe_o), .irq(irq_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
    #1;
  endtask

  task automatic rd(input logic [1:0] a);
    bus_addr = a;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0]);
      chk("R1 rdata bidir", rd_a, (a == 1) ? 0 : 0);
      chk("R1 rdata in", rd_r, 0);
    end
    chk("R1 irq", {irq_a, irq_r, irq_f, irq_o}, 0);
    chk("R1 pin_out", po_a | po_o, 0);
    chk("R1 oe bidir", oe_a, 0);
    chk("R1 oe in", oe_r, 0);
    chk("R1 oe out", oe_o, 4'hF);

    // R2 and R9 output latch sweep
    for (int v = 0; v < 16; v++) begin
      wr(2'd0, v[W-1:0]);
      chk("R2 pin_out bidir", po_a, v);
      chk("R2 pin_out outonly", po_o, v);
      chk("R2 pin_out inonly", po_r, 0);
      rd(2'd0);
      chk("R9 outonly data read", rd_o, v);
    end

    // R3 direction sweep
    for (int v = 0; v < 16; v++) begin
      wr(2'd1, v[W-1:0]);
      chk("R3 oe bidir", oe_a, v);
      rd(2'd1);
      chk("R3 dir readback", rd_f, v);
      chk("R3 oe inonly", oe_r, 0);
      chk("R3 oe outonly", oe_o, 4'hF);
    end

    // R4 R5 R6 R9 edge sweep over all pin transitions
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        @(negedge clk); pins = a[W-1:0];
        repeat (4) @(negedge clk);
        wr(2'd3, 4'hF);
        rd(2'd3);
        chk("R7 cleared", rd_a | rd_r | rd_f, 0);
        @(negedge clk); pins = b[W-1:0];
        repeat (2) @(negedge clk);
        rd(2'd0);
        chk("R9 data after two edges", rd_a, b);
        chk("R9 data inonly", rd_r, b);
        rd(2'd3);
        chk("R6 no capture after two edges", rd_a | rd_r | rd_f, 0);
        @(negedge clk); #1;
        chk("R6 any edge", rd_a, a ^ b);
        chk("R4 rising edge", rd_r, b & ~a);
        chk("R5 falling edge", rd_f, a & ~b);
        chk("R6 outonly no capture", rd_o, 0);
      end
    end

    // R7 sticky and partial clear
    @(negedge clk); pins = 0;
    repeat (4) @(negedge clk);
    wr(2'd3, 4'hF);
    @(negedge clk); pins = 4'hF;
    repeat (10) @(negedge clk);
    rd(2'd3);
    chk("R7 sticky", rd_a, 4'hF);
    wr(2'd3, 4'h5);
    rd(2'd3);
    chk("R7 partial clear", rd_a, 4'hA);
    wr(2'd3, 4'h0);
    rd(2'd3);
    chk("R7 zero write keeps", rd_a, 4'hA);

    // R8 mask sweep
    for (int m = 0; m < 16; m++) begin
      wr(2'd2, m[W-1:0]);
      rd(2'd2);
      chk("R8 mask readback", rd_a, m);
      chk("R8 irq", irq_a, ((m & 4'hA) != 0) ? 1 : 0);
    end
    wr(2'd3, 4'hF);
    chk("R8 irq after clear", irq_a, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule